// File: doc/BRIEF.md
# Link Training Status Checker

This block reads a six-byte link status snapshot taken during DisplayPort link training. For the active lane count it reports whether clock recovery has finished and whether channel equalization has finished. The two results are combinational, so they are valid in the same cycle as the snapshot. For every lane it also extracts the requested voltage swing and pre-emphasis from the adjust-request bytes. It places both fields in the training-set byte layout, ready for the next training write.

A wait timer paces the status polling. The training controller pulses `timer_start` and waits for `timer_done`. The wait length is taken when the timer starts. It depends on the training phase and on the read-interval capability byte. Issuing the training patterns and performing the AUX reads belong to the surrounding controller.

Snapshot byte map, where byte k occupies `status_bytes[8k+7:8k]`:

| Byte | Contents |
|------|----------|
| 0 | Status for lanes 0 and 1 |
| 1 | Status for lanes 2 and 3 |
| 2 | Alignment status |
| 3 | Sink status (not used) |
| 4 | Adjust requests for lanes 0 and 1 |
| 5 | Adjust requests for lanes 2 and 3 |

Top module: `lt_status_eval`

## Requirements
- R1: Lane n's status nibble sits in snapshot byte n>>1. An even lane uses bits [3:0] and an odd lane uses bits [7:4]. Within the nibble, bit 0 is CR-done, bit 1 is EQ-done and bit 2 is symbol-locked.
- R2: `cr_ok` is 1 exactly when every lane n below `lane_cnt` has CR-done set.
- R3: `eq_ok` is 0 whenever bit 0 (interlane-align-done) of snapshot byte 2 is clear.
- R4: `eq_ok` is 1 exactly when the align bit is set and every active lane has CR-done, EQ-done and symbol-locked all set. It follows that `eq_ok` implies `cr_ok`.
- R5: Adjust-request byte 4+(n>>1) holds lane n's fields. For an even lane the swing is in [1:0] and the pre-emphasis in [3:2]; for an odd lane the swing is in [5:4] and the pre-emphasis in [7:6]. Output byte n of `train_set` carries the swing in [1:0] and the pre-emphasis in [4:3], with all other bits 0.
- R6: When the interval byte is 0, the wait is 100 µs in the clock-recovery phase (`phase_eq`=0) and 400 µs in the equalization phase (`phase_eq`=1).
- R7: When the interval byte is N≠0, the wait is N×4 ms in either phase.
- R8: `timer_done` is high for one cycle only. It rises exactly W = µs×`CLK_PER_US` cycles after the clock edge that samples `timer_start`. Phase and interval are taken at that edge.
- R9: A `timer_start` while the timer runs restarts it: no pulse belongs to the earlier start, and the wait is counted from the new start.
- R10: During and after reset `timer_done` is 0, and a start held during reset launches nothing.
- R11: Lanes at or above `lane_cnt`, byte 3 and bits [7:1] of byte 2 have no effect on `cr_ok` or `eq_ok`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_bytes | input | 48 | Snapshot, byte k at [8k+7:8k] |
| lane_cnt | input | 3 | Active lane count: 1, 2 or 4 |
| rd_interval | input | 8 | Training read-interval capability byte |
| phase_eq | input | 1 | 0 = clock recovery, 1 = equalization |
| timer_start | input | 1 | Starts or restarts the wait timer |
| cr_ok | output | 1 | Clock recovery done on all active lanes |
| eq_ok | output | 1 | Equalization done and lanes aligned |
| train_set | output | 32 | Per-lane training-set byte, lane n at [8n+7:8n] |
| timer_done | output | 1 | One-cycle pulse when the wait ends |

## Verification
The assertions assume `timer_start` is a clean synchronous input. They also assume every wait lasts well over one cycle, so a done pulse can never be followed at once by another pulse. That holds for any `CLK_PER_US` of at least 1. The stimulus changes inputs only on falling edges. It drives `lane_cnt` only with 1, 2 or 4. It runs the timer with one clock per microsecond so that even the multi-millisecond waits stay short. It also changes phase and interval just after each start to show they were captured at the start.

// File: rtl/lt_status_eval.sv
module lt_status_eval #(
  parameter int LANES      = 4,
  parameter int CLK_PER_US = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [47:0]       status_bytes,
  input  logic [2:0]        lane_cnt,
  input  logic [7:0]        rd_interval,
  input  logic              phase_eq,
  input  logic              timer_start,
  output logic              cr_ok,
  output logic              eq_ok,
  output logic [8*LANES-1:0] train_set,
  output logic              timer_done
);
  localparam int SHORT_CR = 100 * CLK_PER_US;
  localparam int SHORT_EQ = 400 * CLK_PER_US;
  localparam int UNIT_4MS = 4000 * CLK_PER_US;
  localparam int MAX_WAIT = 255 * UNIT_4MS;
  localparam int CW       = $clog2(MAX_WAIT + 1);
  localparam int ADJ_BASE = 32;
  localparam int ALN_BIT  = 16;

  logic [LANES-1:0] cr_lane, eq_lane;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int NB = (g >> 1) * 8 + (g & 1) * 4;
    localparam int AB = ADJ_BASE + (g >> 1) * 8 + (g & 1) * 4;
    logic [3:0] nib;
    logic       act;
    assign nib = status_bytes[NB +: 4];
    assign act = 3'(g) < lane_cnt;
    assign cr_lane[g] = !act || nib[0];
    assign eq_lane[g] = !act || (&nib[2:0]);
    assign train_set[8*g +: 8] = {3'b000, status_bytes[AB+2 +: 2], 1'b0, status_bytes[AB +: 2]};
  end

  assign cr_ok = &cr_lane;
  assign eq_ok = status_bytes[ALN_BIT] && (&eq_lane);

  logic [CW-1:0] wait_len, cnt;
  logic          busy;

  always_comb begin
    if (rd_interval == 8'd0) wait_len = phase_eq ? CW'(SHORT_EQ) : CW'(SHORT_CR);
    else                     wait_len = CW'(rd_interval) * CW'(UNIT_4MS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      busy       <= 1'b0;
      timer_done <= 1'b0;
    end else if (timer_start) begin
      cnt        <= wait_len - CW'(1);
      busy       <= 1'b1;
      timer_done <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy       <= 1'b0;
        timer_done <= 1'b1;
      end else begin
        cnt        <= cnt - CW'(1);
        timer_done <= 1'b0;
      end
    end else begin
      timer_done <= 1'b0;
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timer_done |=> !timer_done);
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    timer_start |=> !timer_done);
  a_r10_done_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_done) |-> $past(busy));
  a_r3_eq_needs_align: assert property (@(posedge clk) disable iff (!rst_n)
    eq_ok |-> status_bytes[ALN_BIT]);
  a_r4_eq_implies_cr: assert property (@(posedge clk) disable iff (!rst_n)
    eq_ok |-> cr_ok);
  a_r5_spare_bits: assert property (@(posedge clk) disable iff (!rst_n)
    train_set[7:5] == 3'b000 && train_set[2] == 1'b0);
endmodule

// File: tb/sim_lt_status_eval.sv
`timescale 1ns/1ps
module sim_lt_status_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] status_bytes = '0;
  logic [2:0]  lane_cnt = 3'd4;
  logic [7:0]  rd_interval = '0;
  logic        phase_eq = 1'b0;
  logic        timer_start = 1'b0;
  logic        cr_ok, eq_ok, timer_done;
  logic [31:0] train_set;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lt_status_eval #(.LANES(4), .CLK_PER_US(1)) u0 (
    .clk(clk), .rst_n(rst_n), .status_bytes(status_bytes), .lane_cnt(lane_cnt),
    .rd_interval(rd_interval), .phase_eq(phase_eq), .timer_start(timer_start),
    .cr_ok(cr_ok), .eq_ok(eq_ok), .train_set(train_set), .timer_done(timer_done));

  // {snapshot, lane count, expected cr_ok, expected eq_ok}
  localparam int NV = 10;
  localparam logic [52:0] VEC [NV] = '{
    {48'h0000_0001_7777, 3'd4, 1'b1, 1'b1},
    {48'h0000_0001_3777, 3'd4, 1'b1, 1'b0},
    {48'h0000_0001_3777, 3'd2, 1'b1, 1'b1},
    {48'h0000_0001_7077, 3'd4, 1'b0, 1'b0},
    {48'h0000_0001_7077, 3'd2, 1'b1, 1'b1},
    {48'h0000_0000_7777, 3'd4, 1'b1, 1'b0},
    {48'h0000_0001_7717, 3'd2, 1'b1, 1'b0},
    {48'h0000_0001_7717, 3'd1, 1'b1, 1'b1},
    {48'h0000_0001_7770, 3'd1, 1'b0, 1'b0},
    {48'h0000_FFFE_7777, 3'd4, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic run_timer(input logic ph, input logic [7:0] iv, input int expn, input string req);
    int k;
    @(negedge clk);
    phase_eq = ph; rd_interval = iv; timer_start = 1'b1;
    @(negedge clk);
    timer_start = 1'b0; phase_eq = ~ph; rd_interval = 8'hAA;
    k = 0;
    while (!timer_done && k < expn + 10) begin
      @(negedge clk);
      k++;
    end
    chk(k == expn, req, 64'(k), 64'(expn));
    @(negedge clk);
    chk(!timer_done, {req, " pulse width (R8)"}, 64'(timer_done), 64'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int k;
    timer_start = 1'b1;
    repeat (3) @(negedge clk);
    chk(timer_done == 1'b0, "R10 done low in reset", 64'(timer_done), 64'd0);
    rst_n = 1'b1;
    timer_start = 1'b0;
    k = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (timer_done) k++;
    end
    chk(k == 0, "R10 start during reset ignored", 64'(k), 64'd0);

    for (int i = 0; i < NV; i++) begin
      status_bytes = VEC[i][52:5];
      lane_cnt = VEC[i][4:2];
      @(negedge clk);
      chk(cr_ok == VEC[i][1], $sformatf("R2/R1/R11 cr_ok vector %0d", i), 64'(cr_ok), 64'(VEC[i][1]));
      chk(eq_ok == VEC[i][0], $sformatf("R3/R4/R11 eq_ok vector %0d", i), 64'(eq_ok), 64'(VEC[i][0]));
    end

    // R5: byte4=E4, byte5=1B
    status_bytes = 48'h1BE4_0000_0000;
    @(negedge clk);
    chk(train_set == 32'h0113_1A08, "R5 adjust mapping", 64'(train_set), 64'h0113_1A08);
    status_bytes = 48'hFFFF_0000_0000;
    @(negedge clk);
    chk(train_set == 32'h1B1B_1B1B, "R5 full fields", 64'(train_set), 64'h1B1B_1B1B);

    run_timer(1'b0, 8'd0, 100, "R6 CR short wait");
    run_timer(1'b1, 8'd0, 400, "R6 EQ short wait");
    run_timer(1'b0, 8'd1, 4000, "R7 interval 1 CR");
    run_timer(1'b1, 8'd2, 8000, "R7 interval 2 EQ");

    // R9: restart midway
    @(negedge clk);
    phase_eq = 1'b0; rd_interval = 8'd0; timer_start = 1'b1;
    @(negedge clk);
    timer_start = 1'b0;
    k = 0;
    for (int i = 0; i < 49; i++) begin
      @(negedge clk);
      if (timer_done) k++;
    end
    phase_eq = 1'b1; timer_start = 1'b1;
    @(negedge clk);
    timer_start = 1'b0;
    for (int i = 0; i < 399; i++) begin
      @(negedge clk);
      if (timer_done) k++;
    end
    chk(k == 0, "R9 no pulse before restarted wait ends", 64'(k), 64'd0);
    @(negedge clk);
    chk(timer_done == 1'b1, "R9 pulse 400 after restart", 64'(timer_done), 64'd1);
    @(negedge clk);
    chk(timer_done == 1'b0, "R8 single cycle after restart", 64'(timer_done), 64'd0);

    finished = 1;
    summary();
    $finish;
  end
endmodule